// File: doc/BRIEF.md
# Iterative Soft-Decision Threshold Decoder for the Length-7 Cyclic Code

This block decodes one word of the (7,3) cyclic code built on the difference set {0,2,3} modulo 7. Every bit has three parity checks that are orthogonal on it. The block takes seven signed channel log-likelihood values and refines them over a programmed number of iterations. In each iteration it computes, for every bit at the same time, an extrinsic estimate from the three checks. It then forms a soft output and builds the next iteration's input from the channel value plus one third of that estimate. When the last iteration completes, the block registers seven saturated soft outputs and their hard decisions and pulses a completion flag.

A check's reliability comes from a min-sum approximation: the smaller magnitude of the two other bits in the check. Its sign is the product of their signs. All arithmetic is fixed point. Inputs are 6-bit two's complement. Intermediate values and outputs saturate to 9 bits. The one-third scaling is a shift-add with a stated rounding, so a software model can match the hardware bit for bit.

Top module: `siso_thresh_dec`

## Requirements
- R1: While reset is active and after it is released, `busy_o`, `done_o`, `soft_llr_o` and `hard_bits_o` are all zero.
- R2: Channel value j occupies `chan_llr_i[6j+5:6j]` and soft output j occupies `soft_llr_o[9j+8:9j]`, both as signed two's complement. `hard_bits_o[j]` is 1 exactly when soft output j is negative.
- R3: The three checks of bit j have these partner pairs, with indices taken modulo 7: (j+4, j+5), (j+2, j+6) and (j+1, j+3). Each check contributes the smaller partner magnitude. That contribution is negated when the two partners' sign bits differ; a value of zero counts as positive. The extrinsic value E of bit j is the sum of the three contributions, kept at full precision.
- R4: The soft output of bit j is the channel value plus E, saturated to 9 bits.
- R5: The first iteration uses the channel values as its input. Each later iteration uses, for each bit, the channel value plus floor((Es·85 + 128) / 256), saturated to 9 bits. Es is E from the previous iteration, saturated to 9 bits.
- R6: An accepted start runs N iterations, where N is `iter_count_i`, or 1 when that input is 0. `done_o` is high for exactly one cycle, N clock edges after the edge that accepted the start.
- R7: Every saturation clamps to the range -256 to 255.
- R8: The block ignores `start_i` while it is busy. Outputs change only at the edge that raises `done_o` and then hold.
- R9: `busy_o` rises on the edge that accepts a start, stays high throughout the run, and is low in the cycle where `done_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to load the channel values and begin decoding |
| iter_count_i | input | 4 | Number of iterations (0 is treated as 1) |
| chan_llr_i | input | 42 | Seven signed 6-bit channel values, bit j at [6j+5:6j] |
| busy_o | output | 1 | A decode is in progress |
| done_o | output | 1 | One-cycle pulse: results are valid |
| soft_llr_o | output | 63 | Seven signed 9-bit soft outputs |
| hard_bits_o | output | 7 | Hard decisions, 1 for a negative soft output |

## Verification
With N iterations, the results and the `done_o` pulse become visible N clock edges after the edge that samples `start_i`, and `busy_o` is high from the edge after that sample. The bench drives and samples on falling edges and counts those edges from the start request to the first one that shows `done_o`; it expects N+1. Soft and hard outputs are compared in that same cycle against an integer model of the min-sum and shift-add arithmetic written in the bench. They are compared again several cycles later to confirm that they hold and that a start issued during a run left no trace.

// File: rtl/siso_thresh_pkg.sv
// Shared constants and check geometry for the length-7 soft threshold decoder.
// Assumes the cyclic code built on the difference set {0,2,3} mod 7.
package siso_thresh_pkg;

    localparam int CODE_LEN = 7;
    localparam int CHECKS   = 3;

    // Index of member m (0 or 1) of check c among the checks orthogonal on bit j.
    function automatic int nbr_idx(input int j, input int c, input int m);
        int off;
        case (c)
            0:       off = (m == 0) ? 4 : 5;
            1:       off = (m == 0) ? 2 : 6;
            default: off = (m == 0) ? 1 : 3;
        endcase
        return (j + off) % CODE_LEN;
    endfunction

endpackage

// File: rtl/siso_check_term.sv
// One check's signed min-sum contribution: the smaller magnitude of the two
// partner values, negated when their signs differ. Purely combinational.
// Assumes the inputs are two's complement; a zero counts as positive.
module siso_check_term #(
    parameter int ACC_W = 9
) (
    input  logic signed [ACC_W-1:0] a_i,
    input  logic signed [ACC_W-1:0] b_i,
    output logic signed [ACC_W+1:0] term_o
);

    localparam int MW = ACC_W + 1;

    logic signed [MW-1:0] a_ext, b_ext;
    logic        [MW-1:0] a_mag, b_mag, m_mag;
    logic signed [MW:0]   m_ext;

    // Magnitudes, their minimum, then apply the sign product.
    always_comb begin
        a_ext  = {a_i[ACC_W-1], a_i};
        b_ext  = {b_i[ACC_W-1], b_i};
        a_mag  = a_ext[MW-1] ? $unsigned(-a_ext) : $unsigned(a_ext);
        b_mag  = b_ext[MW-1] ? $unsigned(-b_ext) : $unsigned(b_ext);
        m_mag  = (a_mag < b_mag) ? a_mag : b_mag;
        m_ext  = $signed({1'b0, m_mag});
        term_o = (a_i[ACC_W-1] ^ b_i[ACC_W-1]) ? -m_ext : m_ext;
    end

endmodule

// File: rtl/siso_bit_unit.sv
// Per-bit decode slice: sums three check terms into the extrinsic value,
// forms the saturated soft output and the next iteration's input
// (channel + extrinsic * 85/256, rounded by +128 then floor).
// Assumes the neighbour values arrive paired by check: [2c], [2c+1].
module siso_bit_unit
    import siso_thresh_pkg::*;
#(
    parameter int IN_W  = 6,
    parameter int ACC_W = 9
) (
    input  logic signed [IN_W-1:0]  ch_i,
    input  logic signed [ACC_W-1:0] nbr_i [2*CHECKS],
    output logic signed [ACC_W-1:0] soft_o,
    output logic signed [ACC_W-1:0] next_o
);

    localparam int TW  = ACC_W + 2;
    localparam int SW  = ACC_W + 4;
    localparam int PW  = ACC_W + 8;
    localparam int RND = 128;
    localparam int SH  = 8;
    localparam logic signed [SW-1:0] HI = SW'(2**(ACC_W-1) - 1);
    localparam logic signed [SW-1:0] LO = -SW'(2**(ACC_W-1));

    logic signed [TW-1:0]    term [CHECKS];
    logic signed [SW-1:0]    e_full, soft_full, next_full;
    logic signed [ACC_W-1:0] e_sat;
    logic signed [PW-1:0]    pe, prod, scaled;

    // Clamp a wide value into the accumulator range.
    function automatic logic signed [ACC_W-1:0] clamp(input logic signed [SW-1:0] v);
        if (v > HI)      return {1'b0, {(ACC_W-1){1'b1}}};
        else if (v < LO) return {1'b1, {(ACC_W-1){1'b0}}};
        else             return v[ACC_W-1:0];
    endfunction

    generate
        for (genvar c = 0; c < CHECKS; c++) begin : g_chk
            siso_check_term #(.ACC_W(ACC_W)) u_term (
                .a_i    (nbr_i[2*c]),
                .b_i    (nbr_i[2*c+1]),
                .term_o (term[c])
            );
        end
    endgenerate

    // Extrinsic sum, soft output, and scaled feedback for the next pass.
    always_comb begin
        e_full = '0;
        for (int c = 0; c < CHECKS; c++) e_full = e_full + SW'(term[c]);
        soft_full = SW'(ch_i) + e_full;
        soft_o    = clamp(soft_full);
        e_sat     = clamp(e_full);
        pe        = PW'(e_sat);
        prod      = (pe <<< 6) + (pe <<< 4) + (pe <<< 2) + pe + PW'(RND);
        scaled    = prod >>> SH;
        next_full = SW'(ch_i) + SW'(scaled);
        next_o    = clamp(next_full);
    end

endmodule

// File: rtl/siso_iter_ctrl.sv
// Run controller: accepts a start when idle, counts iterations down and
// pulses done on the edge that completes the last one.
// Assumes an iteration count of zero means one iteration.
module siso_iter_ctrl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] iters_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             load_o,
    output logic             last_o
);

    logic [CNT_W-1:0] cnt_q;

    assign load_o = start_i & ~busy_o;
    assign last_o = busy_o & (cnt_q == CNT_W'(1));

    // Sequence a run: idle -> busy for N cycles -> done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_o <= 1'b0;
            done_o <= 1'b0;
            cnt_q  <= '0;
        end else begin
            done_o <= 1'b0;
            if (!busy_o) begin
                if (start_i) begin
                    busy_o <= 1'b1;
                    cnt_q  <= (iters_i == '0) ? CNT_W'(1) : iters_i;
                end
            end else begin
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    busy_o <= 1'b0;
                    done_o <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/siso_thresh_dec.sv
// Iterative soft-in soft-out threshold decoder for the length-7 cyclic code.
// One full iteration over all seven bits per clock; results are registered
// on the final iteration and held until the next completion.
// Assumes channel values are already scaled by the channel reliability.
module siso_thresh_dec
    import siso_thresh_pkg::*;
#(
    parameter int IN_W  = 6,
    parameter int ACC_W = 9,
    parameter int CNT_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [CNT_W-1:0]           iter_count_i,
    input  logic [CODE_LEN*IN_W-1:0]   chan_llr_i,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [CODE_LEN*ACC_W-1:0]  soft_llr_o,
    output logic [CODE_LEN-1:0]        hard_bits_o
);

    logic signed [IN_W-1:0]  ch_q   [CODE_LEN];
    logic signed [ACC_W-1:0] x_q    [CODE_LEN];
    logic signed [ACC_W-1:0] soft_w [CODE_LEN];
    logic signed [ACC_W-1:0] next_w [CODE_LEN];
    logic signed [ACC_W-1:0] soft_q [CODE_LEN];
    logic [CODE_LEN-1:0]     hard_q;
    logic                    load, last;

    siso_iter_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_i),
        .iters_i (iter_count_i),
        .busy_o  (busy_o),
        .done_o  (done_o),
        .load_o  (load),
        .last_o  (last)
    );

    generate
        for (genvar j = 0; j < CODE_LEN; j++) begin : g_bit
            logic signed [ACC_W-1:0] nbr [2*CHECKS];
            for (genvar k = 0; k < 2*CHECKS; k++) begin : g_nbr
                localparam int SRC = nbr_idx(j, k / 2, k % 2);
                assign nbr[k] = x_q[SRC];
            end
            siso_bit_unit #(.IN_W(IN_W), .ACC_W(ACC_W)) u_bit (
                .ch_i   (ch_q[j]),
                .nbr_i  (nbr),
                .soft_o (soft_w[j]),
                .next_o (next_w[j])
            );
            assign soft_llr_o[j*ACC_W +: ACC_W] = soft_q[j];
            assign hard_bits_o[j]               = hard_q[j];
        end
    endgenerate

    // Load channel values, advance the iteration state, capture final results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int j = 0; j < CODE_LEN; j++) begin
                ch_q[j]   <= '0;
                x_q[j]    <= '0;
                soft_q[j] <= '0;
            end
            hard_q <= '0;
        end else begin
            if (load) begin
                for (int j = 0; j < CODE_LEN; j++) begin
                    ch_q[j] <= $signed(chan_llr_i[j*IN_W +: IN_W]);
                    x_q[j]  <= ACC_W'($signed(chan_llr_i[j*IN_W +: IN_W]));
                end
            end else if (busy_o) begin
                for (int j = 0; j < CODE_LEN; j++) x_q[j] <= next_w[j];
            end
            if (last) begin
                for (int j = 0; j < CODE_LEN; j++) begin
                    soft_q[j] <= soft_w[j];
                    hard_q[j] <= soft_w[j][ACC_W-1];
                end
            end
        end
    end

endmodule

// File: rtl/siso_thresh_chk.sv
// Protocol checker for the threshold decoder: run length, pulse shape,
// start acceptance and output hold. Attached by bind below.
module siso_thresh_chk #(
    parameter int CNT_W = 4,
    parameter int OUT_W = 63,
    parameter int HB_W  = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [CNT_W-1:0] iter_count_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [OUT_W-1:0] soft_llr_o,
    input logic [HB_W-1:0]  hard_bits_o
);

    logic [CNT_W:0]   run_len;
    logic [CNT_W-1:0] want;

    // Count busy cycles of the current run and remember its requested length.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            want    <= '0;
        end else if (start_i && !busy_o) begin
            run_len <= '0;
            want    <= (iter_count_i == '0) ? CNT_W'(1) : iter_count_i;
        end else if (busy_o) begin
            run_len <= run_len + 1'b1;
        end
    end

    // R6
    run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (run_len == {1'b0, want}));

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R9
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R9
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((soft_llr_o != $past(soft_llr_o)) || (hard_bits_o != $past(hard_bits_o))) |-> done_o);

endmodule

bind siso_thresh_dec siso_thresh_chk #(
    .CNT_W (CNT_W),
    .OUT_W (CODE_LEN*ACC_W),
    .HB_W  (CODE_LEN)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .iter_count_i (iter_count_i),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .soft_llr_o   (soft_llr_o),
    .hard_bits_o  (hard_bits_o)
);

// File: tb/sim_siso_thresh_dec.sv
module sim_siso_thresh_dec;

    localparam int IN_W  = 6;
    localparam int ACC_W = 9;
    localparam int CNT_W = 4;
    localparam int NB    = 7;
    localparam int NROW  = 12;
    // iterations, then channel values for bits 0..6
    localparam int TBL [NROW][8] = '{
        '{1,  10, 10, 10, 10, 10, 10, 10},
        '{1,  -5, 10, 10, 10, 10, 10, 10},
        '{2,  31, 31, 31, 31, 31, 31, 31},
        '{3, -32,-32,-32,-32,-32,-32,-32},
        '{4,  12, -3,  7,-20,  5,  0, -1},
        '{5, -32, 31,-32, 31,-32, 31,-32},
        '{6,   1, -1,  2, -2,  3, -3,  4},
        '{8,  20,-18, 15,  9,-30,  6,-11},
        '{15, -7, 25,-14,  3,-29, 17,  0},
        '{0,   9, -9,  9, -9,  9, -9,  9},
        '{2,   0,  0,  0,  0,  0,  0,  0},
        '{7, -31,-30, 28,-27, 26,-25, 24}
    };

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic                 start_i;
    logic [CNT_W-1:0]     iter_count_i;
    logic [NB*IN_W-1:0]   chan_llr_i;
    logic                 busy_o, done_o;
    logic [NB*ACC_W-1:0]  soft_llr_o;
    logic [NB-1:0]        hard_bits_o;

    int errs   = 0;
    int checks = 0;
    int ref_soft [NB];

    always #5 clk = ~clk;

    siso_thresh_dec #(.IN_W(IN_W), .ACC_W(ACC_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .iter_count_i(iter_count_i),
        .chan_llr_i(chan_llr_i), .busy_o(busy_o), .done_o(done_o),
        .soft_llr_o(soft_llr_o), .hard_bits_o(hard_bits_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int sat9(input int v);
        if (v > 255)  return 255;
        if (v < -256) return -256;
        return v;
    endfunction

    function automatic int ext_of(input int x[NB], input int j);
        int o1[3] = '{4, 2, 1};
        int o2[3] = '{5, 6, 3};
        int s = 0;
        for (int c = 0; c < 3; c++) begin
            int a = x[(j + o1[c]) % NB];
            int b = x[(j + o2[c]) % NB];
            int ma = (a < 0) ? -a : a;
            int mb = (b < 0) ? -b : b;
            int m = (ma < mb) ? ma : mb;
            s += ((a < 0) != (b < 0)) ? -m : m;
        end
        return s;
    endfunction

    task automatic ref_run(input int ch[NB], input int iters);
        int x[NB];
        int nx[NB];
        int n = (iters == 0) ? 1 : iters;
        for (int j = 0; j < NB; j++) x[j] = ch[j];
        for (int it = 0; it < n; it++) begin
            for (int j = 0; j < NB; j++) begin
                int e = ext_of(x, j);
                ref_soft[j] = sat9(ch[j] + e);
                nx[j] = sat9(ch[j] + ((sat9(e) * 85 + 128) >>> 8));
            end
            for (int j = 0; j < NB; j++) x[j] = nx[j];
        end
    endtask

    function automatic int soft_at(input int j);
        return int'($signed(soft_llr_o[j*ACC_W +: ACC_W]));
    endfunction

    task automatic drive(input int ch[NB], input int iters);
        for (int j = 0; j < NB; j++) chan_llr_i[j*IN_W +: IN_W] = IN_W'(ch[j]);
        iter_count_i = CNT_W'(iters);
        start_i = 1'b1;
    endtask

    // Start a run at a falling edge; return the falling-edge count to done.
    task automatic run_dec(input int ch[NB], input int iters, output int lat, output bit busy_seen);
        drive(ch, iters);
        @(negedge clk);
        start_i = 1'b0;
        busy_seen = busy_o;
        lat = 1;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic cmp_ref(input string tag);
        logic [NB-1:0] eh;
        for (int j = 0; j < NB; j++) begin
            chk(soft_at(j) == ref_soft[j], tag, soft_at(j), ref_soft[j]);
            eh[j] = (ref_soft[j] < 0);
        end
        chk(hard_bits_o == eh, "R2 hard decisions", int'(hard_bits_o), int'(eh));
    endtask

    task automatic all_soft(input int exp, input string tag);
        for (int j = 0; j < NB; j++) chk(soft_at(j) == exp, tag, soft_at(j), exp);
    endtask

    initial begin
        #(200000 * 10);
        errs++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int ch[NB];
        int lat;
        bit bs;
        int hold[NB];
        rst_n = 1'b0;
        start_i = 1'b0;
        iter_count_i = '0;
        chan_llr_i = '0;
        repeat (3) @(negedge clk);
        // R1: reset state, during and after reset
        chk(busy_o == 1'b0 && done_o == 1'b0, "R1 flags in reset", int'({busy_o, done_o}), 0);
        chk(soft_llr_o == '0 && hard_bits_o == '0, "R1 outputs in reset", int'(hard_bits_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy_o == 1'b0 && soft_llr_o == '0, "R1 after release", int'(busy_o), 0);

        // Table walk: R2 R3 R4 R5 R7 against the model, R6 latency, R9 busy.
        for (int r = 0; r < NROW; r++) begin
            int n;
            for (int j = 0; j < NB; j++) ch[j] = TBL[r][j+1];
            n = (TBL[r][0] == 0) ? 1 : TBL[r][0];
            run_dec(ch, TBL[r][0], lat, bs);
            ref_run(ch, TBL[r][0]);
            chk(lat == n + 1, "R6 latency", lat, n + 1);
            chk(bs == 1'b1, "R9 busy after accept", int'(bs), 1);
            chk(busy_o == 1'b0, "R9 busy low at done", int'(busy_o), 0);
            cmp_ref("R3/R4/R5/R7 soft output");
            @(negedge clk);
            chk(done_o == 1'b0, "R6 done single cycle", int'(done_o), 0);
        end

        // R3 R4: all +10, one iteration -> each bit 10 + 3*10.
        for (int j = 0; j < NB; j++) ch[j] = 10;
        run_dec(ch, 1, lat, bs);
        all_soft(40, "R4 uniform soft");
        chk(hard_bits_o == '0, "R2 all positive hard", int'(hard_bits_o), 0);
        // R3: bit 0 at -5 lies in exactly one check of every other bit -> all 25.
        ch[0] = -5;
        run_dec(ch, 1, lat, bs);
        all_soft(25, "R3 single weak bit");
        // R5: all +31, two iterations -> feedback 31+31, soft 31+186.
        for (int j = 0; j < NB; j++) ch[j] = 31;
        run_dec(ch, 2, lat, bs);
        all_soft(217, "R5 scaled feedback");
        // R7: three iterations overflow the soft sum -> clamp at 255.
        run_dec(ch, 3, lat, bs);
        all_soft(255, "R7 saturation");
        // R6: count zero behaves as one iteration.
        for (int j = 0; j < NB; j++) ch[j] = 10;
        run_dec(ch, 0, lat, bs);
        chk(lat == 2, "R6 zero count latency", lat, 2);
        all_soft(40, "R6 zero count result");

        // R8: a start issued mid-run is ignored; outputs then hold.
        for (int j = 0; j < NB; j++) ch[j] = TBL[7][j+1];
        ref_run(ch, 8);
        drive(ch, 8);
        @(negedge clk);
        start_i = 1'b0;
        @(negedge clk);
        for (int j = 0; j < NB; j++) hold[j] = -20;
        drive(hold, 1);
        @(negedge clk);
        start_i = 1'b0;
        lat = 3;
        while (!done_o && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        chk(lat == 9, "R8 run length unchanged", lat, 9);
        cmp_ref("R8 result of first run");
        repeat (5) begin
            @(negedge clk);
            chk(done_o == 1'b0 && busy_o == 1'b0, "R8 no second run", int'({busy_o, done_o}), 0);
        end
        cmp_ref("R8 outputs held");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule